// File: doc/BRIEF.md
# Single-Port RAM with Selectable Write Behaviour

This block is a synchronous single-port memory: one clock, one address, one data input and one data output. Each clock edge with the access enable high performs either a read (write enable low) or a write (write enable high) on the addressed word. A read loads the stored word into the output register, so it appears one clock after the access.

What the output shows during a write is fixed at build time by the `MODE` parameter. It can show the word being written, the word that the write replaced, or it can keep the last value read. An optional second output register, selected by `OUT_PIPE`, adds one clock of read latency. That register has its own load enable, so it can stall while the memory keeps being accessed. A synchronous output reset sets both output registers to the value in `RST_VAL` and leaves the memory contents alone. Every word holds zero when the block starts up.

Top module: `spram_wm`

## Requirements
- R1: A read cycle (en=1, we=0, out_rst=0) loads the word at `addr` into the first output register at that clock edge. With OUT_PIPE=0 it is visible on `rdata` one clock after the access.
- R2: In transparent mode (MODE=WM_TRANSPARENT, encoding 0), a write cycle (en=1, we=1) stores `wdata` at `addr` and loads that same `wdata` into the first output register.
- R3: In read-old mode (MODE=WM_READ_OLD, encoding 1), a write cycle stores `wdata` and loads the value the word held before this write into the first output register. This also holds for back-to-back writes to one address.
- R4: In hold mode (MODE=WM_HOLD, encoding 2), a write cycle stores `wdata` and leaves the first output register unchanged.
- R5: When no MODE is given, the block behaves as transparent mode.
- R6: With en=0 the memory is neither read nor written, and the first output register keeps its value whatever `we`, `addr` and `wdata` are.
- R7: With OUT_PIPE=1, the second register loads the first register's value on every edge where `pipe_en` is 1. Read data therefore reaches `rdata` two clocks after the access.
- R8: With OUT_PIPE=1 and pipe_en=0, `rdata` holds its value while the first register and the memory continue to operate.
- R9: out_rst=1 sets every output register to RST_VAL at that edge, taking priority over en and pipe_en. A write in that same cycle is still stored in memory.
- R10: Every memory word reads as zero before it has been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| out_rst | input | 1 | Synchronous active-high reset of the output registers only |
| en | input | 1 | Access enable; no read or write while low |
| we | input | 1 | Write enable, used when en is high |
| addr | input | ADDR_W | Word address, ADDR_W = $clog2(DEPTH) |
| wdata | input | DATA_W | Data to store on a write |
| pipe_en | input | 1 | Load enable of the optional second output register |
| rdata | output | DATA_W | Read data output |

## Verification
The bench builds four instances side by side from one shared stimulus, all with DATA_W=16, DEPTH=32 and RST_VAL=16'hA5C3. The first instance takes the default mode with no pipeline, which covers R5. Two others set read-old mode and hold mode without a pipeline, so all three write behaviours are compared in the same cycle. The fourth combines read-old mode with OUT_PIPE=1, which brings the two-clock latency, stalls through pipe_en and the reset of the second register within reach. The small depth lets a full sweep reach the last address, and the non-zero reset value can be told apart from the zero start-up contents.

// File: rtl/spram_pkg.sv
package spram_pkg;

    // What the first output register shows on a write cycle
    typedef enum logic [1:0] {
        WM_TRANSPARENT = 2'd0,
        WM_READ_OLD    = 2'd1,
        WM_HOLD        = 2'd2
    } wm_mode_e;

    // Kind of memory access in the current cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e classify(input logic en, input logic we);
        if (!en)     return OP_IDLE;
        else if (we) return OP_WRITE;
        else         return OP_READ;
    endfunction

    // Does the output register load anything during a write?
    function automatic logic loads_on_write(input wm_mode_e m);
        return m != WM_HOLD;
    endfunction

    // If it loads, does it take the incoming word (otherwise the old one)?
    function automatic logic shows_new(input wm_mode_e m);
        return m == WM_TRANSPARENT;
    endfunction

endpackage

// File: rtl/spram_store.sv
module spram_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] old_word
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Defined start-up contents: all zero
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (wr) mem[addr] <= wdata;
    end

    // Word currently held at addr, before this edge's write
    assign old_word = mem[addr];

endmodule

// File: rtl/spram_out_sel.sv
module spram_out_sel
    import spram_pkg::*;
#(
    parameter int                DATA_W  = 16,
    parameter wm_mode_e          MODE    = WM_TRANSPARENT,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] old_word,
    output logic [DATA_W-1:0] q
);

    logic              load;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        load = 1'b0;
        nxt  = old_word;
        unique case (op)
            OP_READ: begin
                load = 1'b1;
                nxt  = old_word;
            end
            OP_WRITE: begin
                load = loads_on_write(MODE);
                nxt  = shows_new(MODE) ? wdata : old_word;
            end
            default: begin
                load = 1'b0;
                nxt  = old_word;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= RST_VAL;
        else if (load) q <= nxt;
    end

endmodule

// File: rtl/spram_pipe.sv
module spram_pipe #(
    parameter int                DATA_W   = 16,
    parameter bit                OUT_PIPE = 1'b0,
    parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    generate
        if (OUT_PIPE) begin : g_reg
            logic [DATA_W-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst)     stage_q <= RST_VAL;
                else if (ld) stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_bypass
            logic unused_in;
            assign unused_in = clk ^ rst ^ ld;
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/spram_wm.sv
module spram_wm
    import spram_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter int                DEPTH    = 64,
    parameter wm_mode_e          MODE     = WM_TRANSPARENT,
    parameter bit                OUT_PIPE = 1'b0,
    parameter logic [DATA_W-1:0] RST_VAL  = '0,
    localparam int               ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              out_rst,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pipe_en,
    output logic [DATA_W-1:0] rdata
);

    op_e               op;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] latch_q;

    assign op = classify(en, we);

    spram_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk      (clk),
        .wr       (op == OP_WRITE),
        .addr     (addr),
        .wdata    (wdata),
        .old_word (old_word)
    );

    spram_out_sel #(
        .DATA_W  (DATA_W),
        .MODE    (MODE),
        .RST_VAL (RST_VAL)
    ) sel_i (
        .clk      (clk),
        .rst      (out_rst),
        .op       (op),
        .wdata    (wdata),
        .old_word (old_word),
        .q        (latch_q)
    );

    spram_pipe #(
        .DATA_W   (DATA_W),
        .OUT_PIPE (OUT_PIPE),
        .RST_VAL  (RST_VAL)
    ) pipe_i (
        .clk (clk),
        .rst (out_rst),
        .ld  (pipe_en),
        .d   (latch_q),
        .q   (rdata)
    );

endmodule

// File: rtl/spram_wm_chk.sv
module spram_wm_chk
    import spram_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter wm_mode_e          MODE     = WM_TRANSPARENT,
    parameter bit                OUT_PIPE = 1'b0,
    parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
    input logic              clk,
    input logic              out_rst,
    input logic              en,
    input logic              we,
    input logic [DATA_W-1:0] wdata,
    input logic              pipe_en,
    input logic [DATA_W-1:0] latch_q,
    input logic [DATA_W-1:0] rdata
);

    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_rst_latch_R9: assert property (@(posedge clk)
        out_rst |=> latch_q == RST_VAL);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (out_rst)
        (past_ok && !en) |=> $stable(latch_q));

    generate
        if (MODE == WM_TRANSPARENT) begin : g_tr
            assert_write_new_R2: assert property (@(posedge clk) disable iff (out_rst)
                (en && we) |=> latch_q == $past(wdata));
        end
        if (MODE == WM_HOLD) begin : g_hd
            assert_write_hold_R4: assert property (@(posedge clk) disable iff (out_rst)
                (past_ok && en && we) |=> $stable(latch_q));
        end
        if (OUT_PIPE) begin : g_pp
            assert_pipe_load_R7: assert property (@(posedge clk) disable iff (out_rst)
                (past_ok && pipe_en) |=> rdata == $past(latch_q));
            assert_pipe_stall_R8: assert property (@(posedge clk) disable iff (out_rst)
                (past_ok && !pipe_en) |=> $stable(rdata));
            assert_rst_pipe_R9: assert property (@(posedge clk)
                out_rst |=> rdata == RST_VAL);
        end
    endgenerate

endmodule

bind spram_wm spram_wm_chk #(
    .DATA_W   (DATA_W),
    .MODE     (MODE),
    .OUT_PIPE (OUT_PIPE),
    .RST_VAL  (RST_VAL)
) chk_i (
    .clk     (clk),
    .out_rst (out_rst),
    .en      (en),
    .we      (we),
    .wdata   (wdata),
    .pipe_en (pipe_en),
    .latch_q (latch_q),
    .rdata   (rdata)
);

// File: tb/spram_wm_tb_top.sv
`timescale 1ns/1ps
module spram_wm_tb_top;
    import spram_pkg::*;

    localparam int              DW = 16;
    localparam int              DP = 32;
    localparam int              AW = $clog2(DP);
    localparam logic [DW-1:0]   RV = 16'hA5C3;

    logic          clk = 1'b0;
    logic          out_rst = 1'b0;
    logic          en = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          pipe_en = 1'b0;
    logic [DW-1:0] q_tr, q_ro, q_hd, q_pp;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Default mode, no pipeline (R5)
    spram_wm #(.DATA_W(DW), .DEPTH(DP), .RST_VAL(RV)) dut_i (
        .clk(clk), .out_rst(out_rst), .en(en), .we(we), .addr(addr),
        .wdata(wdata), .pipe_en(pipe_en), .rdata(q_tr));

    spram_wm #(.DATA_W(DW), .DEPTH(DP), .MODE(WM_READ_OLD), .RST_VAL(RV)) dut_ro (
        .clk(clk), .out_rst(out_rst), .en(en), .we(we), .addr(addr),
        .wdata(wdata), .pipe_en(pipe_en), .rdata(q_ro));

    spram_wm #(.DATA_W(DW), .DEPTH(DP), .MODE(WM_HOLD), .RST_VAL(RV)) dut_hd (
        .clk(clk), .out_rst(out_rst), .en(en), .we(we), .addr(addr),
        .wdata(wdata), .pipe_en(pipe_en), .rdata(q_hd));

    spram_wm #(.DATA_W(DW), .DEPTH(DP), .MODE(WM_READ_OLD), .OUT_PIPE(1'b1),
               .RST_VAL(RV)) dut_pp (
        .clk(clk), .out_rst(out_rst), .en(en), .we(we), .addr(addr),
        .wdata(wdata), .pipe_en(pipe_en), .rdata(q_pp));

    // Reference model, built from the requirements
    logic [DW-1:0] ref_mem [DP];
    logic [DW-1:0] exp_tr, exp_ro, exp_hd, exp_pp;

    task automatic chk(input string tag, input string who,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, who, got, exp);
        end
    endtask

    // One clock: drive at negedge, model the edge, check at next negedge
    task automatic step(input logic e, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic r, input logic p,
                        input string tag);
        logic [DW-1:0] old, nxt_pp;
        en = e; we = w; addr = a; wdata = d; out_rst = r; pipe_en = p;
        @(posedge clk);
        old    = ref_mem[a];
        nxt_pp = p ? exp_ro : exp_pp;
        if (e) begin
            if (w) begin
                exp_tr     = d;
                exp_ro     = old;
                ref_mem[a] = d;
            end else begin
                exp_tr = old;
                exp_ro = old;
                exp_hd = old;
            end
        end
        if (r) begin
            exp_tr = RV; exp_ro = RV; exp_hd = RV; nxt_pp = RV;
        end
        exp_pp = nxt_pp;
        @(negedge clk);
        chk(tag, "transparent", q_tr, exp_tr);
        chk(tag, "read-old",    q_ro, exp_ro);
        chk(tag, "hold",        q_hd, exp_hd);
        chk(tag, "pipelined",   q_pp, exp_pp);
    endtask

    task automatic t_reset;
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, "R9");
        chk("R9", "reset value", q_tr, RV);
    endtask

    task automatic t_zero_start;
        step(1'b1, 1'b0, 5'd0,  '0, 1'b0, 1'b1, "R10");
        step(1'b1, 1'b0, 5'd5,  '0, 1'b0, 1'b1, "R10");
        chk("R10", "unwritten word", q_ro, 16'h0000);
        step(1'b1, 1'b0, 5'd31, '0, 1'b0, 1'b1, "R1");
    endtask

    task automatic t_write_modes;
        step(1'b1, 1'b0, 5'd3, '0, 1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, 5'd5, 16'h1111, 1'b0, 1'b1, "R2");
        chk("R5", "default mode shows new", q_tr, 16'h1111);
        chk("R3", "old word shown", q_ro, 16'h0000);
        chk("R4", "hold keeps last read", q_hd, 16'h0000);
        step(1'b1, 1'b0, 5'd5, '0, 1'b0, 1'b1, "R1");
        chk("R1", "read back", q_hd, 16'h1111);
    endtask

    task automatic t_back_to_back;
        step(1'b1, 1'b1, 5'd7, 16'hAAAA, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, 5'd7, 16'hBBBB, 1'b0, 1'b1, "R3");
        chk("R3", "second write shows first", q_ro, 16'hAAAA);
        chk("R2", "second write shows new", q_tr, 16'hBBBB);
        step(1'b1, 1'b1, 5'd7, 16'hCCCC, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b0, 5'd7, '0, 1'b0, 1'b1, "R1");
    endtask

    task automatic t_write_after_read;
        step(1'b1, 1'b0, 5'd5, '0, 1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, 5'd5, 16'h2222, 1'b0, 1'b1, "R3");
        chk("R4", "hold after read", q_hd, 16'h1111);
        step(1'b1, 1'b0, 5'd9, '0, 1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, 5'd9, 16'h3434, 1'b0, 1'b1, "R2");
    endtask

    task automatic t_disabled;
        step(1'b1, 1'b0, 5'd7, '0, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, 5'd5, 16'hFFFF, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b0, 5'd9, 16'h0F0F, 1'b0, 1'b1, "R6");
        chk("R6", "idle keeps output", q_tr, 16'hCCCC);
        step(1'b1, 1'b0, 5'd5, '0, 1'b0, 1'b1, "R6");
        chk("R6", "idle write not stored", q_tr, 16'h2222);
    endtask

    task automatic t_pipe;
        step(1'b1, 1'b0, 5'd9, '0, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b0, 5'd7, '0, 1'b0, 1'b1, "R7");
        chk("R7", "two-clock latency", q_pp, 16'h3434);
        step(1'b1, 1'b0, 5'd5, '0, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b1, 5'd5, 16'h5656, 1'b0, 1'b0, "R8");
        chk("R8", "stalled output", q_pp, 16'h3434);
        step(1'b0, 1'b0, 5'd0, '0, 1'b0, 1'b1, "R7");
        chk("R7", "resume after stall", q_pp, 16'h2222);
    endtask

    task automatic t_reset_mid;
        step(1'b1, 1'b1, 5'd12, 16'h3333, 1'b1, 1'b0, "R9");
        chk("R9", "reset over write", q_tr, RV);
        chk("R9", "reset over stall", q_pp, RV);
        step(1'b1, 1'b0, 5'd12, '0, 1'b0, 1'b1, "R9");
        chk("R9", "write kept through reset", q_tr, 16'h3333);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 16'h0101) ^ 16'h5A00;
    endfunction

    task automatic t_sweep;
        for (int i = 0; i < DP; i++)
            step(1'b1, 1'b1, AW'(i), pat(i), 1'b0, 1'b1, "R2");
        for (int i = DP - 1; i >= 0; i--)
            step(1'b1, 1'b0, AW'(i), '0, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, "R7");
        chk("R1", "word 0 after sweep", q_pp, pat(0));
    endtask

    initial begin
        for (int i = 0; i < DP; i++) ref_mem[i] = '0;
        exp_tr = 'x; exp_ro = 'x; exp_hd = 'x; exp_pp = 'x;
        fork
            begin
                @(negedge clk);
                t_reset();
                t_zero_start();
                t_write_modes();
                t_back_to_back();
                t_write_after_read();
                t_disabled();
                t_pipe();
                t_reset_mid();
                t_sweep();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule